// File: doc/BRIEF.md
# Legacy I/O Decode Control

This block holds a 16-bit control word for the legacy audio functions of a sound controller. It uses the word to decide which function claims each incoming I/O cycle. Configuration software reads and writes the word through a 32-bit port with byte enables. Only the two low byte lanes carry storage.

For every I/O access the block receives the 16-bit address and one base address for each function. It reports a hit for the Sound Blaster window, the FM synthesizer window, the MPU401 window and the joystick window. It also gives a one-hot claim vector that settles any overlap by priority. It produces the MPU401 interrupt request from received MIDI bytes, and that request is gated by the control word. When FM mapping is switched on, a programmable countdown holds FM accesses off until the synthesizer has settled.

Top module: `legacy_io_decode`

## Requirements
- R1: After reset the control word reads 0x907F on `cfg_rdata[15:0]`, and `cfg_rdata[31:16]` always reads zero.
- R2: A write changes only the byte lanes whose `cfg_be` bit is set, and lanes 2 and 3 have no effect. Bit 14 is reserved and always reads 0. All other bits read back as written.
- R3: Control bit 15 is the decode-disable flag. A window hits only while `io_valid` is 1, bit 15 is 0 and that function's enable is 1. The enables are bit 0 for Sound Blaster, bit 1 for FM, bit 2 for joystick and bit 3 for MPU401.
- R4: A window matches when the address lies in base to base+size-1. The sizes are 16 bytes for Sound Blaster, 4 for FM, 2 for MPU401 and 1 for joystick.
- R5: With control bit 5 at 1, only address bits [9:0] are compared against the base. With bit 5 at 0, all 16 bits are compared.
- R6: Offsets 0x0-0x3 and 0x8-0x9 of an enabled Sound Blaster window raise `hit_fm` instead of `hit_sb`, whatever the value of the FM enable.
- R7: `claim_sel` is one-hot or zero. Bit 0 is Sound Blaster, bit 1 FM, bit 2 MPU401 and bit 3 joystick. It selects the first hitting window in that order.
- R8: When the FM enable goes from 0 to 1, `fm_busy` rises in the cycle the write lands. It stays high for FM_HOLD_CYCLES further clock edges. While `fm_busy` is high, `hit_fm` stays 0.
- R9: A `midi_rx` pulse sets `mpu_irq` at the next edge when decode is active, the MPU401 enable (bit 3) is 1 and the MPU401 interrupt enable (bit 4) is 1. The request then holds.
- R10: A `mpu_data_rd` pulse clears a pending `mpu_irq` at the next edge.
- R11: Clearing bit 3 or bit 4, or setting bit 15, drops `mpu_irq` as soon as the write lands. A `midi_rx` pulse that arrives while the request is gated off is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Control word read data |
| io_valid | input | 1 | An I/O cycle is present |
| io_addr | input | 16 | I/O cycle address |
| sb_base | input | 16 | Sound Blaster window base |
| fm_base | input | 16 | FM window base |
| mpu_base | input | 16 | MPU401 window base |
| gp_base | input | 16 | Joystick window base |
| hit_sb | output | 1 | Sound Blaster window hit |
| hit_fm | output | 1 | FM hit (own window or routed from Sound Blaster) |
| hit_mpu | output | 1 | MPU401 window hit |
| hit_gp | output | 1 | Joystick window hit |
| claim_sel | output | 4 | Prioritised one-hot claim |
| fm_busy | output | 1 | FM settle hold-off active |
| midi_rx | input | 1 | One-cycle pulse per received MIDI byte |
| mpu_data_rd | input | 1 | One-cycle pulse reading MPU401 receive data |
| mpu_irq | output | 1 | Gated MPU401 interrupt request |

## Verification
The assertions assume that `midi_rx` and `mpu_data_rd` are pulses sampled on the clock. They also assume FM_HOLD_CYCLES is at least one, so that an FM enable rise always produces a busy period. The bench drives all strobes at falling edges for exactly one cycle and builds the bench with a short hold count. Base addresses stay fixed during a check, so every hit reflects a stable set of windows. The bench waits out the settle period after each control write, so decode checks do not overlap an FM hold-off.

// File: rtl/lio_pkg.sv
// Package: shared constants for the legacy I/O decode block.
// Assumes a 16-bit control word; bit positions below are decoded by
// the window logic and interrupt gating, so they are fixed.
package lio_pkg;

    localparam int CTRL_W   = 16;
    localparam int NWIN     = 4;

    // Window indices, also the claim priority order (lowest wins)
    localparam int WIN_SB   = 0;
    localparam int WIN_FM   = 1;
    localparam int WIN_MPU  = 2;
    localparam int WIN_GP   = 3;

    // Control word bit positions
    localparam int B_SB_EN   = 0;
    localparam int B_FM_EN   = 1;
    localparam int B_GP_EN   = 2;
    localparam int B_MPU_EN  = 3;
    localparam int B_MIRQ_EN = 4;
    localparam int B_ALIAS   = 5;
    localparam int B_RSVD    = 14;
    localparam int B_DEC_DIS = 15;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h907F;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'hBFFF;

endpackage

// File: rtl/lio_ctrl_reg.sv
// Module: control word storage with byte-lane writes.
// Assumes the word occupies the low byte lanes of a 32-bit port;
// upper lanes carry no storage. Reserved bits never store a 1.
module lio_ctrl_reg
    import lio_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [BUS_W/8-1:0]   be,
    input  logic [BUS_W-1:0]     wdata,
    output logic [CTRL_W-1:0]    ctrl_o
);

    localparam int LANES = CTRL_W / 8;

    logic unused_upper;
    assign unused_upper = ^{be[BUS_W/8-1:LANES], wdata[BUS_W-1:CTRL_W]};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Per-lane storage: load masked write data when lane enabled
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctrl_o[g*8 +: 8] <= CTRL_RESET[g*8 +: 8];
                else if (wr && be[g])
                    ctrl_o[g*8 +: 8] <= wdata[g*8 +: 8] & CTRL_WMASK[g*8 +: 8];
            end
        end
    endgenerate

endmodule

// File: rtl/lio_window.sv
// Module: one address window comparator.
// Computes the offset of the address from the base, optionally wrapped
// to the alias width, and flags a match below SIZE when enabled.
module lio_window #(
    parameter int AW         = 16,
    parameter int ALIAS_BITS = 10,
    parameter int SIZE       = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic          alias_en,
    input  logic          enable,
    output logic          match,
    output logic [AW-1:0] offset
);

    logic [AW-1:0] diff;

    // Offset from base, truncated to the alias width when aliasing
    always_comb begin
        diff = addr - base;
        if (alias_en)
            offset = {{(AW-ALIAS_BITS){1'b0}}, diff[ALIAS_BITS-1:0]};
        else
            offset = diff;
        match = enable && (offset < AW'(SIZE));
    end

endmodule

// File: rtl/lio_fm_settle.sv
// Module: FM settle hold-off counter.
// Assumes HOLD_CYCLES >= 1. A 0->1 change of the FM enable loads the
// counter; busy covers the landing cycle and the countdown.
module lio_fm_settle #(
    parameter int HOLD_CYCLES = 3_300_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fm_en,
    output logic busy
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          fm_en_q;
    logic          rise;

    assign rise = fm_en && !fm_en_q;
    assign busy = rise || (cnt != '0);

    // Track previous enable; reset value matches the reset control word
    always_ff @(posedge clk) begin
        if (!rst_n) fm_en_q <= 1'b1;
        else        fm_en_q <= fm_en;
    end

    // Countdown: load on rise, clear when disabled, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (rise)
            cnt <= CW'(HOLD_CYCLES);
        else if (!fm_en)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/lio_mpu_irq.sv
// Module: MPU401 interrupt request latch.
// Sets on a received byte while gated on, clears on a data read or
// when the gate drops; the output is masked by the gate at once.
module lio_mpu_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic rx,
    input  logic rd,
    output logic irq
);

    logic pend;

    // Pending flag: new byte wins over a simultaneous read
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) pend <= 1'b0;
        else if (rx)         pend <= 1'b1;
        else if (rd)         pend <= 1'b0;
    end

    assign irq = pend && gate;

endmodule

// File: rtl/legacy_io_decode.sv
// Module: legacy I/O decode control top.
// Holds the control word, decodes four function windows, routes the
// FM offsets of the Sound Blaster window, prioritises the claim, and
// gates the MPU401 interrupt. Decode outputs are combinational.
module legacy_io_decode
    import lio_pkg::*;
#(
    parameter int AW            = 16,
    parameter int BUS_W         = 32,
    parameter int ALIAS_BITS    = 10,
    parameter int SB_SIZE       = 16,
    parameter int FM_SIZE       = 4,
    parameter int MPU_SIZE      = 2,
    parameter int GP_SIZE       = 1,
    parameter int FM_RT_LO_SIZE = 4,
    parameter int FM_RT_HI_OFS  = 8,
    parameter int FM_RT_HI_SIZE = 2,
    parameter int FM_HOLD_CYCLES = 3_300_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [BUS_W/8-1:0] cfg_be,
    input  logic [BUS_W-1:0]   cfg_wdata,
    output logic [BUS_W-1:0]   cfg_rdata,
    input  logic               io_valid,
    input  logic [AW-1:0]      io_addr,
    input  logic [AW-1:0]      sb_base,
    input  logic [AW-1:0]      fm_base,
    input  logic [AW-1:0]      mpu_base,
    input  logic [AW-1:0]      gp_base,
    output logic               hit_sb,
    output logic               hit_fm,
    output logic               hit_mpu,
    output logic               hit_gp,
    output logic [NWIN-1:0]    claim_sel,
    output logic               fm_busy,
    input  logic               midi_rx,
    input  logic               mpu_data_rd,
    output logic               mpu_irq
);

    localparam int WIN_SIZE [NWIN] = '{SB_SIZE, FM_SIZE, MPU_SIZE, GP_SIZE};

    logic [CTRL_W-1:0] ctrl_q;
    logic              dec_on;
    logic [AW-1:0]     base  [NWIN];
    logic [AW-1:0]     offs  [NWIN];
    logic [NWIN-1:0]   win_en;
    logic [NWIN-1:0]   match;
    logic [NWIN-1:0]   hits;
    logic              fm_route;

    lio_ctrl_reg #(.BUS_W(BUS_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .ctrl_o (ctrl_q)
    );

    assign cfg_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
    assign dec_on    = !ctrl_q[B_DEC_DIS] && io_valid;

    // Gather per-window base and enable in priority order
    always_comb begin
        base[WIN_SB]    = sb_base;
        base[WIN_FM]    = fm_base;
        base[WIN_MPU]   = mpu_base;
        base[WIN_GP]    = gp_base;
        win_en[WIN_SB]  = dec_on && ctrl_q[B_SB_EN];
        win_en[WIN_FM]  = dec_on && ctrl_q[B_FM_EN];
        win_en[WIN_MPU] = dec_on && ctrl_q[B_MPU_EN];
        win_en[WIN_GP]  = dec_on && ctrl_q[B_GP_EN];
    end

    genvar w;
    generate
        for (w = 0; w < NWIN; w++) begin : g_win
            lio_window #(
                .AW         (AW),
                .ALIAS_BITS (ALIAS_BITS),
                .SIZE       (WIN_SIZE[w])
            ) u_win (
                .addr     (io_addr),
                .base     (base[w]),
                .alias_en (ctrl_q[B_ALIAS]),
                .enable   (win_en[w]),
                .match    (match[w]),
                .offset   (offs[w])
            );
        end
    endgenerate

    lio_fm_settle #(.HOLD_CYCLES(FM_HOLD_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .fm_en (ctrl_q[B_FM_EN]),
        .busy  (fm_busy)
    );

    // FM register offsets inside the Sound Blaster window
    always_comb begin
        fm_route = match[WIN_SB] &&
                   ((offs[WIN_SB] < AW'(FM_RT_LO_SIZE)) ||
                    ((offs[WIN_SB] >= AW'(FM_RT_HI_OFS)) &&
                     (offs[WIN_SB] <  AW'(FM_RT_HI_OFS + FM_RT_HI_SIZE))));
    end

    // Final hit vector after routing and settle suppression
    always_comb begin
        hits          = match;
        hits[WIN_SB]  = match[WIN_SB] && !fm_route;
        hits[WIN_FM]  = (match[WIN_FM] || fm_route) && !fm_busy;
    end

    assign hit_sb  = hits[WIN_SB];
    assign hit_fm  = hits[WIN_FM];
    assign hit_mpu = hits[WIN_MPU];
    assign hit_gp  = hits[WIN_GP];

    // Priority claim: lowest index hit wins
    always_comb begin
        claim_sel = '0;
        for (int i = NWIN - 1; i >= 0; i--)
            if (hits[i]) claim_sel = NWIN'(1) << i;
    end

    lio_mpu_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (!ctrl_q[B_DEC_DIS] && ctrl_q[B_MPU_EN] && ctrl_q[B_MIRQ_EN]),
        .rx    (midi_rx),
        .rd    (mpu_data_rd),
        .irq   (mpu_irq)
    );

endmodule

// File: rtl/lio_decode_chk.sv
// Module: property checker for legacy_io_decode, attached by bind.
// Assumes strobes are clock-synchronous pulses and a nonzero hold count.
module lio_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ctrl,
    input logic        hit_sb,
    input logic        hit_fm,
    input logic        hit_mpu,
    input logic        hit_gp,
    input logic [3:0]  claim_sel,
    input logic        fm_busy,
    input logic        midi_rx,
    input logic        mpu_data_rd,
    input logic        mpu_irq
);

    logic gate;
    assign gate = !ctrl[15] && ctrl[3] && ctrl[4];

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[14]);

    // R3
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[15] |-> !(hit_sb || hit_fm || hit_mpu || hit_gp));

    // R3
    gp_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_gp |-> ctrl[2]);

    // R7
    claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_sel) && ((claim_sel != 4'b0) ==
            (hit_sb || hit_fm || hit_mpu || hit_gp)));

    // R8
    fm_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[1]) |-> fm_busy);

    // R8
    busy_blocks_fm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fm_busy |-> !hit_fm);

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (midi_rx && gate) |=> (mpu_irq || !gate));

    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mpu_irq |-> gate);

    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mpu_data_rd && !midi_rx) |=> !mpu_irq);

endmodule

bind legacy_io_decode lio_decode_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl_q),
    .hit_sb      (hit_sb),
    .hit_fm      (hit_fm),
    .hit_mpu     (hit_mpu),
    .hit_gp      (hit_gp),
    .claim_sel   (claim_sel),
    .fm_busy     (fm_busy),
    .midi_rx     (midi_rx),
    .mpu_data_rd (mpu_data_rd),
    .mpu_irq     (mpu_irq)
);

// File: tb/legacy_io_decode_test.sv
// Bench: vector table of decode cases, then directed tests.
module legacy_io_decode_test;

    localparam int HOLD = 8;
    localparam int NV   = 22;

    // {control word, address, expected hits {gp,mpu,fm,sb}}
    localparam logic [35:0] VECS [NV] = '{
        {16'h003F, 16'h0220, 4'b0010},
        {16'h003F, 16'h0224, 4'b0001},
        {16'h003F, 16'h022F, 4'b0001},
        {16'h003F, 16'h0230, 4'b0000},
        {16'h003F, 16'h0228, 4'b0010},
        {16'h003F, 16'h022A, 4'b0001},
        {16'h003F, 16'h0388, 4'b0010},
        {16'h003F, 16'h038B, 4'b0010},
        {16'h003F, 16'h038C, 4'b0000},
        {16'h003F, 16'h0201, 4'b1000},
        {16'h003F, 16'h0202, 4'b0000},
        {16'h003F, 16'h0331, 4'b0100},
        {16'h003F, 16'h0332, 4'b0000},
        {16'h003F, 16'hF224, 4'b0001},
        {16'h001F, 16'hF224, 4'b0000},
        {16'h001F, 16'h0224, 4'b0001},
        {16'h0036, 16'h0220, 4'b0000},
        {16'h0036, 16'h0388, 4'b0010},
        {16'h0036, 16'h0331, 4'b0000},
        {16'h003D, 16'h0220, 4'b0010},
        {16'h003D, 16'h0388, 4'b0000},
        {16'h803F, 16'h0224, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic [15:0] sb_base = 16'h0220;
    logic [15:0] fm_base = 16'h0388;
    logic [15:0] mpu_base = 16'h0330;
    logic [15:0] gp_base = 16'h0201;
    logic        hit_sb, hit_fm, hit_mpu, hit_gp;
    logic [3:0]  claim_sel;
    logic        fm_busy;
    logic        midi_rx = 1'b0;
    logic        mpu_data_rd = 1'b0;
    logic        mpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    legacy_io_decode #(.FM_HOLD_CYCLES(HOLD)) uut (
        .clk, .rst_n, .cfg_wr, .cfg_be, .cfg_wdata, .cfg_rdata,
        .io_valid, .io_addr, .sb_base, .fm_base, .mpu_base, .gp_base,
        .hit_sb, .hit_fm, .hit_mpu, .hit_gp, .claim_sel, .fm_busy,
        .midi_rx, .mpu_data_rd, .mpu_irq
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] prio(input logic [3:0] h);
        for (int i = 0; i < 4; i++)
            if (h[i]) return 4'b1 << i;
        return 4'b0;
    endfunction

    task automatic wr_ctrl(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); midi_rx = 1'b1;
        @(negedge clk); midi_rx = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); mpu_data_rd = 1'b1;
        @(negedge clk); mpu_data_rd = 1'b0;
    endtask

    function automatic logic [3:0] hv();
        return {hit_gp, hit_mpu, hit_fm, hit_sb};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value and zero upper half
        chk("R1 reset word", cfg_rdata, 32'h0000_907F);
        // R3 decode disabled at reset
        io_valid = 1'b1; io_addr = 16'h0224;
        chk("R3 no hit while disabled", 32'(hv()), 32'h0);

        // R2 byte lanes
        wr_ctrl(4'b0010, 32'hFFFF_FF00);
        chk("R2 high lane, bit14 reserved", cfg_rdata, 32'h0000_BF7F);
        wr_ctrl(4'b0001, 32'h0000_003F);
        chk("R2 low lane", cfg_rdata, 32'h0000_BF3F);
        wr_ctrl(4'b1100, 32'hFFFF_FFFF);
        chk("R2 upper lanes ignored", cfg_rdata, 32'h0000_BF3F);

        // Table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            wr_ctrl(4'b0011, {16'h0, VECS[v][35:20]});
            io_addr = VECS[v][19:4];
            repeat (HOLD + 4) @(negedge clk);
            chk($sformatf("R4/R7 hits vec %0d", v), 32'(hv()), 32'(VECS[v][3:0]));
            chk($sformatf("R7 claim vec %0d", v), 32'(claim_sel),
                32'(prio(VECS[v][3:0])));
        end

        // R3 io_valid low gives no hit
        wr_ctrl(4'b0011, 32'h003F);
        repeat (HOLD + 4) @(negedge clk);
        io_addr = 16'h0224; io_valid = 1'b0;
        #1 chk("R3 no hit without valid", 32'(hv()), 32'h0);
        io_valid = 1'b1;
        // R5 alias wraps high address bits
        io_addr = 16'h7388;
        #1 chk("R5 aliased FM hit", 32'(hit_fm), 32'h1);
        // R6 routed offset 9, not 0xA
        io_addr = 16'h0229;
        #1 chk("R6 offset 9 routed", 32'(hv()), 32'h2);

        // R7 overlap: joystick moved onto MPU401 base
        gp_base = 16'h0330; io_addr = 16'h0330;
        #1 chk("R7 overlap hits", 32'(hv()), 32'hC);
        chk("R7 MPU401 wins", 32'(claim_sel), 32'h4);
        gp_base = 16'h0201;

        // R8 FM hold-off
        wr_ctrl(4'b0011, 32'h003D);
        io_addr = 16'h0388;
        wr_ctrl(4'b0011, 32'h003F);
        chk("R8 busy on landing", 32'(fm_busy), 32'h1);
        chk("R8 FM suppressed", 32'(hit_fm), 32'h0);
        repeat (HOLD) @(negedge clk);
        chk("R8 busy at last cycle", 32'(fm_busy), 32'h1);
        @(negedge clk);
        chk("R8 busy ends", 32'(fm_busy), 32'h0);
        chk("R8 FM hit after settle", 32'(hit_fm), 32'h1);

        // R9 interrupt set and held
        chk("R9 idle irq", 32'(mpu_irq), 32'h0);
        pulse_rx();
        chk("R9 irq set", 32'(mpu_irq), 32'h1);
        repeat (3) @(negedge clk);
        chk("R9 irq held", 32'(mpu_irq), 32'h1);
        // R10 read clears
        pulse_rd();
        chk("R10 irq cleared", 32'(mpu_irq), 32'h0);
        // R11 enable drop clears at once
        pulse_rx();
        wr_ctrl(4'b0011, 32'h002F);
        chk("R11 drop on MIEN clear", 32'(mpu_irq), 32'h0);
        wr_ctrl(4'b0011, 32'h003F);
        chk("R11 stays cleared", 32'(mpu_irq), 32'h0);
        wr_ctrl(4'b0011, 32'h0037);
        pulse_rx();
        wr_ctrl(4'b0011, 32'h003F);
        chk("R11 gated byte lost", 32'(mpu_irq), 32'h0);
        pulse_rx();
        wr_ctrl(4'b0010, 32'h0000_8000);
        chk("R11 drop on decode disable", 32'(mpu_irq), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule